// File: doc/BRIEF.md
# Low-Power SDRAM Command Decoder

This block sits behind the pins of a low-power SDRAM. It decodes the strobes, address, bank bits, clock enable and data mask that arrive on each rising clock edge into one command per cycle. Every input is first captured in a register. The captured values are decoded, and the result is registered again. Each cycle therefore produces a one-hot command strobe, together with the fields that belong to that command: bank, row, column, auto-precharge request, all-banks flag and mode op-code. Any field the command does not use is driven to zero.

Two pin encodings are split by the clock-enable level. One gives burst terminate or deep power down. The other gives auto refresh or self refresh entry. The bank bits of a mode-register write pick the main or the extended mode register.

The block remembers whether the most recent read or write burst asked for auto precharge. A burst terminate that follows such a burst is refused. The block also carries the data mask forward on two paths. One is a write mask aligned with the decoded command. The other is an output-disable that follows the mask two clocks after it was sampled.

Top module: `lpsdr_cmd_decoder`

## Requirements
- R1: Inputs are captured on a rising edge k. The decoded outputs for them appear after edge k+1. While reset is high, the strobe is NOP and every field, flag, mask and disable output is zero.
- R2: Exactly one bit of `cmd_o` is high every cycle. The bit positions are: 0 deselect, 1 NOP, 2 activate, 3 read, 4 write, 5 burst terminate, 6 deep power down, 7 precharge, 8 auto refresh, 9 self refresh, 10 mode register, 11 extended mode register.
- R3: When chip select (active low) is high, the result is deselect, whatever the other pins carry. When chip select is low, the row-strobe, column-strobe and write-enable bits (active low, in that order) decode as follows: 111 NOP, 011 activate, 101 read, 100 write, 110 burst terminate, 010 precharge, 001 refresh, 000 mode register set.
- R4: Activate outputs bank = bank pins and row = all 13 address bits.
- R5: Read and write output bank = bank pins, column = address[8:0] and auto-precharge = address[10]. `ap_o` is never high for any other command.
- R6: Precharge with address[10] = 1 sets `all_banks_o` and forces the bank output to 0. With address[10] = 0, the bank output is the bank pins.
- R7: The refresh encoding is auto refresh when clock enable is 1 and self refresh when it is 0. All of its fields are zero, whatever the address and bank pins carry.
- R8: The burst-terminate encoding is deep power down when clock enable is 0. When clock enable is 1, it is burst terminate, but only if the last read or write had address[10] = 0. Otherwise the strobe is NOP and `cmd_err_o` is 1.
- R9: Mode register set with bank 00 strobes the main register and with bank 01 the extended one. In both cases the op-code is the 13 address bits. Bank 10 or 11 gives a NOP strobe, a zero op-code and `cmd_err_o` = 1.
- R10: `wr_mask_o` and `wdata_o` carry the mask and data captured alongside the decoded command, with the same latency as `cmd_o`.
- R11: `dq_hiz_o` equals the mask captured two rising edges before `wr_mask_o` is updated for the same sample. That is, it lags `wr_mask_o` by one cycle.
- R12: Fields not used by the decoded command are zero, including on deselect, NOP, burst terminate and deep power down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_i | input | 1 | Clock-enable pin level |
| chip_sel_n_i | input | 1 | Chip select, active low |
| row_sel_n_i | input | 1 | Row strobe, active low |
| col_sel_n_i | input | 1 | Column strobe, active low |
| wr_en_n_i | input | 1 | Write enable, active low |
| bank_i | input | BA_W | Bank address pins |
| addr_i | input | A_W | Address pins |
| mask_i | input | DM_W | Data mask, one bit per byte lane |
| wdata_i | input | DQ_W | Data pins |
| cmd_o | output | 12 | One-hot decoded command |
| bank_o | output | BA_W | Decoded bank |
| row_o | output | A_W | Activate row |
| col_o | output | COL_W | Read/write column |
| ap_o | output | 1 | Auto-precharge request |
| all_banks_o | output | 1 | Precharge of all banks |
| opcode_o | output | A_W | Mode register op-code |
| cmd_err_o | output | 1 | Refused burst terminate or reserved mode register |
| wr_mask_o | output | DM_W | Write mask aligned with `cmd_o` |
| dq_hiz_o | output | DM_W | Read output disable, two clocks after the mask sample |
| wdata_o | output | DQ_W | Data aligned with `cmd_o` |

## Verification
The bench sweeps every combination of clock enable, chip select, strobe code and bank value, with address words that vary from step to step. Its reference model keeps its own copy of the auto-precharge history.

A decoder that ignored clock enable would report burst terminate where deep power down was sent, or auto refresh where self refresh entry was sent. A decoder that tracked the wrong burst would accept a burst terminate after an auto-precharged read, or refuse a legal one. A design that leaked address bits into idle fields would show non-zero row or op-code on refresh and deselect. A design that mishandled the bank bits on precharge or mode set would select the wrong mode register or miss a reserved value.

A streamed mask pattern catches a disable path that is one cycle too short or too long. A single-edge probe catches an output that skips the input register.

// File: rtl/lpsdr_cmd_pkg.sv
package lpsdr_cmd_pkg;
  localparam int NCMD    = 12;
  localparam int HIZ_LAG = 2;

  typedef enum logic [3:0] {
    C_DESEL = 4'd0,
    C_NOP   = 4'd1,
    C_ACT   = 4'd2,
    C_RD    = 4'd3,
    C_WR    = 4'd4,
    C_BST   = 4'd5,
    C_DPD   = 4'd6,
    C_PRE   = 4'd7,
    C_ARF   = 4'd8,
    C_SREF  = 4'd9,
    C_MRS   = 4'd10,
    C_EMRS  = 4'd11
  } cmd_e;

  localparam logic [2:0] RCW_NOP = 3'b111;
  localparam logic [2:0] RCW_ACT = 3'b011;
  localparam logic [2:0] RCW_RD  = 3'b101;
  localparam logic [2:0] RCW_WR  = 3'b100;
  localparam logic [2:0] RCW_BST = 3'b110;
  localparam logic [2:0] RCW_PRE = 3'b010;
  localparam logic [2:0] RCW_REF = 3'b001;
  localparam logic [2:0] RCW_MRS = 3'b000;
endpackage

// File: rtl/sdr_in_reg.sv
module sdr_in_reg #(
  parameter int BA_W = 2,
  parameter int A_W  = 13,
  parameter int DM_W = 2,
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cke_d,
  input  logic            cs_n_d,
  input  logic [2:0]      rcw_d,
  input  logic [BA_W-1:0] ba_d,
  input  logic [A_W-1:0]  a_d,
  input  logic [DM_W-1:0] dm_d,
  input  logic [DQ_W-1:0] dq_d,
  output logic            cke_q,
  output logic            cs_n_q,
  output logic [2:0]      rcw_q,
  output logic [BA_W-1:0] ba_q,
  output logic [A_W-1:0]  a_q,
  output logic [DM_W-1:0] dm_q,
  output logic [DQ_W-1:0] dq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q  <= 1'b1;
      cs_n_q <= 1'b1;
      rcw_q  <= 3'b111;
      ba_q   <= '0;
      a_q    <= '0;
      dm_q   <= '0;
      dq_q   <= '0;
    end else begin
      cke_q  <= cke_d;
      cs_n_q <= cs_n_d;
      rcw_q  <= rcw_d;
      ba_q   <= ba_d;
      a_q    <= a_d;
      dm_q   <= dm_d;
      dq_q   <= dq_d;
    end
  end
endmodule

// File: rtl/sdr_cmd_classify.sv
module sdr_cmd_classify
  import lpsdr_cmd_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int A_W    = 13,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10
) (
  input  logic             cke,
  input  logic             cs_n,
  input  logic [2:0]       rcw,
  input  logic [BA_W-1:0]  ba,
  input  logic [A_W-1:0]   a,
  input  logic             ap_last,
  output cmd_e             idx,
  output logic [BA_W-1:0]  bank,
  output logic [A_W-1:0]   row,
  output logic [COL_W-1:0] col,
  output logic             ap,
  output logic             allb,
  output logic [A_W-1:0]   op,
  output logic             err
);
  always_comb begin
    idx  = C_NOP;
    bank = '0;
    row  = '0;
    col  = '0;
    ap   = 1'b0;
    allb = 1'b0;
    op   = '0;
    err  = 1'b0;
    if (cs_n) begin
      idx = C_DESEL;
    end else begin
      case (rcw)
        RCW_NOP: idx = C_NOP;
        RCW_ACT: begin
          idx  = C_ACT;
          bank = ba;
          row  = a;
        end
        RCW_RD, RCW_WR: begin
          idx  = (rcw == RCW_RD) ? C_RD : C_WR;
          bank = ba;
          col  = a[COL_W-1:0];
          ap   = a[AP_BIT];
        end
        RCW_BST: begin
          if (!cke)         idx = C_DPD;
          else if (ap_last) err = 1'b1;
          else              idx = C_BST;
        end
        RCW_PRE: begin
          idx  = C_PRE;
          allb = a[AP_BIT];
          bank = a[AP_BIT] ? '0 : ba;
        end
        RCW_REF: idx = cke ? C_ARF : C_SREF;
        default: begin
          if (ba == BA_W'(0)) begin
            idx = C_MRS;
            op  = a;
          end else if (ba == BA_W'(1)) begin
            idx = C_EMRS;
            op  = a;
          end else begin
            err = 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sdr_dm_delay.sv
module sdr_dm_delay #(
  parameter int W     = 2,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [DEPTH+1];
  assign stage[0] = din;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[g+1] <= '0;
      else     stage[g+1] <= stage[g];
    end
  end

  assign dout = stage[DEPTH];
endmodule

// File: rtl/lpsdr_cmd_decoder.sv
module lpsdr_cmd_decoder
  import lpsdr_cmd_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int A_W    = 13,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10,
  parameter int DM_W   = 2,
  parameter int DQ_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en_i,
  input  logic             chip_sel_n_i,
  input  logic             row_sel_n_i,
  input  logic             col_sel_n_i,
  input  logic             wr_en_n_i,
  input  logic [BA_W-1:0]  bank_i,
  input  logic [A_W-1:0]   addr_i,
  input  logic [DM_W-1:0]  mask_i,
  input  logic [DQ_W-1:0]  wdata_i,
  output logic [NCMD-1:0]  cmd_o,
  output logic [BA_W-1:0]  bank_o,
  output logic [A_W-1:0]   row_o,
  output logic [COL_W-1:0] col_o,
  output logic             ap_o,
  output logic             all_banks_o,
  output logic [A_W-1:0]   opcode_o,
  output logic             cmd_err_o,
  output logic [DM_W-1:0]  wr_mask_o,
  output logic [DM_W-1:0]  dq_hiz_o,
  output logic [DQ_W-1:0]  wdata_o
);
  logic            cke_q, cs_n_q;
  logic [2:0]      rcw_q;
  logic [BA_W-1:0] ba_q;
  logic [A_W-1:0]  a_q;
  logic [DM_W-1:0] dm_q;
  logic [DQ_W-1:0] dq_q;

  sdr_in_reg #(.BA_W(BA_W), .A_W(A_W), .DM_W(DM_W), .DQ_W(DQ_W)) u_in (
    .clk(clk), .rst(rst),
    .cke_d(clk_en_i), .cs_n_d(chip_sel_n_i),
    .rcw_d({row_sel_n_i, col_sel_n_i, wr_en_n_i}),
    .ba_d(bank_i), .a_d(addr_i), .dm_d(mask_i), .dq_d(wdata_i),
    .cke_q(cke_q), .cs_n_q(cs_n_q), .rcw_q(rcw_q), .ba_q(ba_q),
    .a_q(a_q), .dm_q(dm_q), .dq_q(dq_q)
  );

  logic             ap_last;
  cmd_e             dec_idx;
  logic [BA_W-1:0]  dec_bank;
  logic [A_W-1:0]   dec_row, dec_op;
  logic [COL_W-1:0] dec_col;
  logic             dec_ap, dec_allb, dec_err;

  sdr_cmd_classify #(.BA_W(BA_W), .A_W(A_W), .COL_W(COL_W), .AP_BIT(AP_BIT)) u_cls (
    .cke(cke_q), .cs_n(cs_n_q), .rcw(rcw_q), .ba(ba_q), .a(a_q),
    .ap_last(ap_last), .idx(dec_idx), .bank(dec_bank), .row(dec_row),
    .col(dec_col), .ap(dec_ap), .allb(dec_allb), .op(dec_op), .err(dec_err)
  );

  logic [NCMD-1:0] dec_oh;
  for (genvar g = 0; g < NCMD; g++) begin : g_oh
    assign dec_oh[g] = (int'(dec_idx) == g);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o       <= NCMD'(1) << C_NOP;
      bank_o      <= '0;
      row_o       <= '0;
      col_o       <= '0;
      ap_o        <= 1'b0;
      all_banks_o <= 1'b0;
      opcode_o    <= '0;
      cmd_err_o   <= 1'b0;
      wr_mask_o   <= '0;
      wdata_o     <= '0;
      ap_last     <= 1'b0;
    end else begin
      cmd_o       <= dec_oh;
      bank_o      <= dec_bank;
      row_o       <= dec_row;
      col_o       <= dec_col;
      ap_o        <= dec_ap;
      all_banks_o <= dec_allb;
      opcode_o    <= dec_op;
      cmd_err_o   <= dec_err;
      wr_mask_o   <= dm_q;
      wdata_o     <= dq_q;
      if (dec_idx == C_RD || dec_idx == C_WR) ap_last <= dec_ap;
    end
  end

  sdr_dm_delay #(.W(DM_W), .DEPTH(HIZ_LAG)) u_hiz (
    .clk(clk), .rst(rst), .din(dm_q), .dout(dq_hiz_o)
  );
endmodule

// File: rtl/lpsdr_cmd_decoder_chk.sv
module lpsdr_cmd_decoder_chk
  import lpsdr_cmd_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int A_W   = 13,
  parameter int COL_W = 9,
  parameter int DM_W  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [NCMD-1:0]  cmd_o,
  input logic [BA_W-1:0]  bank_o,
  input logic [A_W-1:0]   row_o,
  input logic [COL_W-1:0] col_o,
  input logic             ap_o,
  input logic             all_banks_o,
  input logic [A_W-1:0]   opcode_o,
  input logic             cmd_err_o,
  input logic [DM_W-1:0]  wr_mask_o,
  input logic [DM_W-1:0]  dq_hiz_o
);
  logic seen_ap;
  always_ff @(posedge clk) begin
    if (rst) seen_ap <= 1'b0;
    else if (cmd_o[C_RD] || cmd_o[C_WR]) seen_ap <= ap_o;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones(cmd_o) == 1); // R2
  AST_HIZ_LAG: assert property (@(posedge clk) disable iff (rst)
    dq_hiz_o == $past(wr_mask_o)); // R11
  AST_ALLBANK_PRE: assert property (@(posedge clk) disable iff (rst)
    all_banks_o |-> (cmd_o[C_PRE] && bank_o == '0)); // R6
  AST_AP_RW_ONLY: assert property (@(posedge clk) disable iff (rst)
    ap_o |-> (cmd_o[C_RD] || cmd_o[C_WR])); // R5
  AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cmd_o[C_ARF] || cmd_o[C_SREF]) |->
      (bank_o == '0 && row_o == '0 && col_o == '0 && opcode_o == '0)); // R7
  AST_ERR_AS_NOP: assert property (@(posedge clk) disable iff (rst)
    cmd_err_o |-> cmd_o[C_NOP]); // R8
  AST_BST_NO_AP: assert property (@(posedge clk) disable iff (rst)
    cmd_o[C_BST] |-> !seen_ap); // R8
endmodule

bind lpsdr_cmd_decoder lpsdr_cmd_decoder_chk #(
  .BA_W(BA_W), .A_W(A_W), .COL_W(COL_W), .DM_W(DM_W)
) u_chk (
  .clk(clk), .rst(rst), .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o),
  .col_o(col_o), .ap_o(ap_o), .all_banks_o(all_banks_o),
  .opcode_o(opcode_o), .cmd_err_o(cmd_err_o), .wr_mask_o(wr_mask_o),
  .dq_hiz_o(dq_hiz_o)
);

// File: tb/test_lpsdr_cmd_decoder.sv
module test_lpsdr_cmd_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cke, cs_n, rs_n, cs2_n, we_n;
  logic [1:0]  ba;
  logic [12:0] a;
  logic [1:0]  dm;
  logic [15:0] dq;
  logic [11:0] cmd_o;
  logic [1:0]  bank_o;
  logic [12:0] row_o, opcode_o;
  logic [8:0]  col_o;
  logic        ap_o, all_banks_o, cmd_err_o;
  logic [1:0]  wr_mask_o, dq_hiz_o;
  logic [15:0] wdata_o;

  lpsdr_cmd_decoder i_lpsdr_cmd_decoder (
    .clk(clk), .rst(rst), .clk_en_i(cke), .chip_sel_n_i(cs_n),
    .row_sel_n_i(rs_n), .col_sel_n_i(cs2_n), .wr_en_n_i(we_n),
    .bank_i(ba), .addr_i(a), .mask_i(dm), .wdata_i(dq),
    .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
    .ap_o(ap_o), .all_banks_o(all_banks_o), .opcode_o(opcode_o),
    .cmd_err_o(cmd_err_o), .wr_mask_o(wr_mask_o), .dq_hiz_o(dq_hiz_o),
    .wdata_o(wdata_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int   n_run = 0;
  int   n_fail = 0;
  logic exp_ap = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic k, input logic c, input logic [2:0] rcw,
                       input logic [1:0] b, input logic [12:0] ad,
                       input logic [1:0] m, input logic [15:0] d);
    cke = k; cs_n = c; {rs_n, cs2_n, we_n} = rcw; ba = b; a = ad; dm = m; dq = d;
  endtask

  // Called at a negedge; checks the outputs two rising edges later.
  task automatic apply(input logic k, input logic c, input logic [2:0] rcw,
                       input logic [1:0] b, input logic [12:0] ad,
                       input logic [1:0] m, input logic [15:0] d);
    int          e_idx;
    logic [1:0]  e_bank;
    logic [12:0] e_row, e_op;
    logic [8:0]  e_col;
    logic        e_ap, e_all, e_err;
    drive(k, c, rcw, b, ad, m, d);
    e_idx = 1; e_bank = '0; e_row = '0; e_op = '0; e_col = '0;
    e_ap = 0; e_all = 0; e_err = 0;
    if (c) e_idx = 0;
    else case (rcw)
      3'b111: e_idx = 1;
      3'b011: begin e_idx = 2; e_bank = b; e_row = ad; end
      3'b101, 3'b100: begin
        e_idx = (rcw == 3'b101) ? 3 : 4;
        e_bank = b; e_col = ad[8:0]; e_ap = ad[10];
      end
      3'b110: begin
        if (!k) e_idx = 6;
        else if (exp_ap) e_err = 1;
        else e_idx = 5;
      end
      3'b010: begin e_idx = 7; e_all = ad[10]; e_bank = ad[10] ? 2'b00 : b; end
      3'b001: e_idx = k ? 8 : 9;
      default: begin
        if (b == 2'd0) begin e_idx = 10; e_op = ad; end
        else if (b == 2'd1) begin e_idx = 11; e_op = ad; end
        else e_err = 1;
      end
    endcase
    if (!c && (rcw == 3'b101 || rcw == 3'b100)) exp_ap = ad[10];
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2 R3 R8 R9 command strobe", 64'(cmd_o), 64'(12'(1) << e_idx));
    chk("R4 R5 R6 R7 R12 fields",
        64'({bank_o, row_o, col_o, ap_o, all_banks_o, opcode_o}),
        64'({e_bank, e_row, e_col, e_ap, e_all, e_op}));
    chk("R8 R9 error flag", 64'(cmd_err_o), 64'(e_err));
    chk("R10 aligned mask and data", 64'({wr_mask_o, wdata_o}), 64'({m, d}));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] dm_hist [4];
    rst = 1'b1;
    drive(1'b1, 1'b1, 3'b111, 2'b11, 13'h1fff, 2'b11, 16'hffff);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 reset strobe", 64'(cmd_o), 64'(12'h002));
    chk("R1 reset fields", 64'({bank_o, row_o, col_o, ap_o, all_banks_o, opcode_o}), 64'(0));
    chk("R1 reset flags", 64'({cmd_err_o, wr_mask_o, dq_hiz_o, wdata_o}), 64'(0));
    rst = 1'b0;

    // R1: latency probe (deselect, then activate seen only after two edges)
    apply(1'b1, 1'b1, 3'b111, 2'b00, 13'h0, 2'b00, 16'h0);
    drive(1'b1, 1'b0, 3'b011, 2'b10, 13'h0abc, 2'b00, 16'h0);
    @(posedge clk); @(negedge clk);
    chk("R1 one edge later still old", 64'(cmd_o), 64'(12'h001));
    @(posedge clk); @(negedge clk);
    chk("R1 two edges later activate", 64'({cmd_o, row_o}), 64'({12'h004, 13'h0abc}));

    // Exhaustive sweep over clock enable, select, strobe code and bank.
    for (int i = 0; i < 128; i++) begin
      logic [12:0] ad;
      ad = 13'((i * 829) ^ (i << 6) ^ (i << 10));
      apply(i[6], i[5], i[4:2], i[1:0], ad, i[1:0], 16'(i * 4099));
    end

    // R8: directed burst-terminate legality
    apply(1'b1, 1'b0, 3'b101, 2'b01, 13'h0400, 2'b00, 16'h1);
    apply(1'b1, 1'b0, 3'b110, 2'b00, 13'h0, 2'b00, 16'h2);
    apply(1'b0, 1'b0, 3'b110, 2'b00, 13'h0, 2'b00, 16'h3);
    apply(1'b1, 1'b0, 3'b100, 2'b10, 13'h0000, 2'b01, 16'h4);
    apply(1'b1, 1'b0, 3'b110, 2'b00, 13'h1fff, 2'b00, 16'h5);
    // R6, R7, R9 directed corners
    apply(1'b1, 1'b0, 3'b010, 2'b11, 13'h0400, 2'b00, 16'h6);
    apply(1'b1, 1'b0, 3'b010, 2'b11, 13'h1bff, 2'b00, 16'h7);
    apply(1'b0, 1'b0, 3'b001, 2'b11, 13'h1fff, 2'b11, 16'h8);
    apply(1'b1, 1'b0, 3'b000, 2'b01, 13'h1555, 2'b00, 16'h9);
    apply(1'b1, 1'b0, 3'b000, 2'b11, 13'h0aaa, 2'b00, 16'ha);

    // R11: streamed mask, disable lags the sample by two clocks
    for (int j = 0; j < 40; j++) begin
      logic [1:0] m;
      m = 2'((j * 7) ^ (j >> 2));
      if (j >= 3) begin
        chk("R11 output disable lag", 64'(dq_hiz_o), 64'(dm_hist[(j - 3) % 4]));
        chk("R10 mask lag", 64'(wr_mask_o), 64'(dm_hist[(j - 2) % 4]));
      end
      drive(1'b1, 1'b1, 3'b111, 2'b00, 13'h0, m, 16'h0);
      dm_hist[j % 4] = m;
      @(negedge clk);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule